// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns asynchronous external interrupt pins (two by default) into interrupt requests for a processor core. Each pin first passes through a synchronizer into the clock domain. A two-bit sense field then decides what counts as an interrupt on that pin: a low level, a falling edge or a rising edge. One code is reserved and produces nothing. An edge is caught by a pending flag, which stays set until the core acknowledges it. A level request is never caught: it is present only while the synchronized pin is low.

A pin's request reaches the core only when the global interrupt enable and that pin's mask bit are both set. A masked edge still sets the pending flag, so the interrupt is delivered once the mask is opened. Each pin has its own pending state machine. It has two states: `PND_IDLE` (nothing pending) and `PND_SET` (edge caught). There are two transitions. *Catch* goes from `PND_IDLE` to `PND_SET` on a selected edge event. *Acknowledge* goes from `PND_SET` to `PND_IDLE` when the acknowledge input is high and no new edge event occurs in that same cycle. Every other case keeps the current state.

Top module: `xirq_sense_ctrl`

## Requirements
- R1: While reset is active and right after it is released, every `pend_o` and `req_o` bit is 0.
- R2: Sense code 00 (level): `req_o` is high while the synchronized pin is low, and it drops once the synchronized pin is high again. It never sets `pend_o`.
- R3: Sense code 01 is reserved: it never sets `pend_o` and never raises `req_o` through the level path.
- R4: Sense code 10 sets `pend_o` on a falling edge of the pin, and sense code 11 sets it on a rising edge. The opposite edge has no effect.
- R5: The pin passes through two flops before any use. A level request appears after the second rising clock edge that samples the new pin value. A pending flag appears after the third.
- R6: An edge pulse that lasts one full clock period is always caught.
- R7: `req_o[i]` equals `gie_i & mask_i[i] & (pend_o[i] | level request)`.
- R8: With `mask_i[i]` low, a selected edge still sets `pend_o[i]`. `req_o[i]` then rises in the same cycle that the mask is set.
- R9: An acknowledge pulse clears a set pending flag on the next clock edge. An acknowledge pulse on a pin with nothing pending has no effect. Without an acknowledge, a set pending flag stays set.
- R10: If a selected edge event and an acknowledge for the same pin fall in the same cycle, `pend_o` stays set.
- R11: Changing the sense code while the pin is steady creates no edge event. The edge history keeps updating in every mode.
- R12: Pins are independent: activity or acknowledges on one pin leave every other pin's `pend_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | NUM_PINS | Asynchronous external interrupt pins |
| sense_cfg_i | input | 2*NUM_PINS | Sense code per pin; pin i uses bits [2i+1:2i]. 00 low level, 01 reserved, 10 falling edge, 11 rising edge |
| mask_i | input | NUM_PINS | Per-pin request enable |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | NUM_PINS | Per-pin acknowledge pulse that clears the pending flag |
| req_o | output | NUM_PINS | Qualified interrupt request to the core |
| pend_o | output | NUM_PINS | Per-pin pending flag for caught edges |

## Verification
A pending state machine stuck in `PND_SET` shows up at the ports one cycle after an acknowledge, as a `pend_o` that fails to clear. A machine that never enters `PND_SET` shows up three clock edges after the pin edge, as a missing `pend_o`. Damage in the synchronizer or the history register shows up as a latency of two or three edges that is off by one. It can also appear as a spurious catch right after a sense-code change. Errors in the gating logic are visible in the same cycle, because `req_o` follows the enables combinationally.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    // Sense-control encoding per pin
    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_RSVD = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    // Pending-flag state per pin
    typedef enum logic {
        PND_IDLE = 1'b0,
        PND_SET  = 1'b1
    } pend_state_e;

endpackage

// File: rtl/xirq_pin_sync.sv
// Multi-flop synchronizer with a one-cycle history register behind it.
module xirq_pin_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic sync_o,
    output logic prev_o
);

    logic [STAGES-1:0] chain_q;
    logic              hist_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
            hist_q  <= RESET_VAL;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_i};
            // history updates every cycle regardless of sense mode
            hist_q  <= chain_q[STAGES-1];
        end
    end

    assign sync_o = chain_q[STAGES-1];
    assign prev_o = hist_q;

endmodule

// File: rtl/xirq_edge_decode.sv
// Turns the synchronized pin and its history into a level request and an edge event.
module xirq_edge_decode
    import xirq_pkg::*;
(
    input  logic   sync_i,
    input  logic   prev_i,
    input  sense_e mode_i,
    output logic   level_o,
    output logic   event_o
);

    logic fell;
    logic rose;

    assign fell = prev_i & ~sync_i;
    assign rose = ~prev_i & sync_i;

    always_comb begin
        level_o = 1'b0;
        event_o = 1'b0;
        unique case (mode_i)
            SENSE_LOW:  level_o = ~sync_i;
            SENSE_RSVD: begin
                level_o = 1'b0;
                event_o = 1'b0;
            end
            SENSE_FALL: event_o = fell;
            SENSE_RISE: event_o = rose;
        endcase
    end

endmodule

// File: rtl/xirq_pend_fsm.sv
// Per-pin pending flag: PND_IDLE --catch--> PND_SET --acknowledge--> PND_IDLE
module xirq_pend_fsm
    import xirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic event_i,
    input  logic ack_i,
    output logic pend_o
);

    pend_state_e state_q;
    pend_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PND_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PND_IDLE: if (event_i)            state_d = PND_SET;  // catch
            PND_SET:  if (ack_i && !event_i)  state_d = PND_IDLE; // acknowledge; a new edge wins
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            PND_IDLE: pend_o = 1'b0;
            PND_SET:  pend_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/xirq_sense_ctrl.sv
// Top: per-pin synchronizer, sense decode, pending FSM and request gating.
module xirq_sense_ctrl
    import xirq_pkg::*;
#(
    parameter int NUM_PINS    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_i,
    input  logic [2*NUM_PINS-1:0] sense_cfg_i,
    input  logic [NUM_PINS-1:0]   mask_i,
    input  logic                  gie_i,
    input  logic [NUM_PINS-1:0]   ack_i,
    output logic [NUM_PINS-1:0]   req_o,
    output logic [NUM_PINS-1:0]   pend_o
);

    localparam int CFG_W = 2;

    logic [NUM_PINS-1:0] sync_s;
    logic [NUM_PINS-1:0] prev_s;
    logic [NUM_PINS-1:0] level_s;
    logic [NUM_PINS-1:0] event_s;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        sense_e mode;
        assign mode = sense_e'(sense_cfg_i[CFG_W*i +: CFG_W]);

        xirq_pin_sync #(
            .STAGES    (SYNC_STAGES),
            .RESET_VAL (1'b1)
        ) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pin_i[i]),
            .sync_o (sync_s[i]),
            .prev_o (prev_s[i])
        );

        xirq_edge_decode u_dec (
            .sync_i  (sync_s[i]),
            .prev_i  (prev_s[i]),
            .mode_i  (mode),
            .level_o (level_s[i]),
            .event_o (event_s[i])
        );

        xirq_pend_fsm u_pend (
            .clk     (clk),
            .rst_n   (rst_n),
            .event_i (event_s[i]),
            .ack_i   (ack_i[i]),
            .pend_o  (pend_o[i])
        );

        assign req_o[i] = gie_i & mask_i[i] & (pend_o[i] | level_s[i]);
    end

endmodule

// File: rtl/xirq_sense_chk.sv
// Port-level checker, bound into the top.
module xirq_sense_chk #(
    parameter int NUM_PINS = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [2*NUM_PINS-1:0] sense_cfg_i,
    input logic [NUM_PINS-1:0]   mask_i,
    input logic                  gie_i,
    input logic [NUM_PINS-1:0]   ack_i,
    input logic [NUM_PINS-1:0]   req_o,
    input logic [NUM_PINS-1:0]   pend_o
);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
        // R7: no request without both enables
        p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !(gie_i && mask_i[i]) |-> !req_o[i]);

        // R2 and R3: level and reserved codes never catch an edge
        p_no_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!sense_cfg_i[2*i+1] && !pend_o[i]) |=> !pend_o[i]);

        // R3: reserved code with nothing pending gives no request
        p_reserved_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (sense_cfg_i[2*i +: 2] == 2'b01 && !pend_o[i]) |-> !req_o[i]);

        // R9: pending flag holds without acknowledge
        p_pend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_o[i] && !ack_i[i]) |=> pend_o[i]);

        // R4: a catch only follows an edge-mode code
        p_edge_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_o[i]) |-> $past(sense_cfg_i[2*i+1]));

        // R8: a pending flag with enables open is always requested
        p_pend_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_o[i] && gie_i && mask_i[i]) |-> req_o[i]);
    end

endmodule

bind xirq_sense_ctrl xirq_sense_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sense_cfg_i (sense_cfg_i),
    .mask_i      (mask_i),
    .gie_i       (gie_i),
    .ack_i       (ack_i),
    .req_o       (req_o),
    .pend_o      (pend_o)
);

// File: tb/sim_xirq_sense_ctrl.sv
`timescale 1ns/1ps
module sim_xirq_sense_ctrl;

    localparam int NP = 2;
    localparam int WATCHDOG_CYC = 200000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin = '1;
    logic [2*NP-1:0] cfg = '0;
    logic [NP-1:0] mask = '1;
    logic          gie = 1'b1;
    logic [NP-1:0] ack = '0;
    logic [NP-1:0] req;
    logic [NP-1:0] pend;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    xirq_sense_ctrl #(.NUM_PINS(NP), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .sense_cfg_i(cfg),
        .mask_i(mask), .gie_i(gie), .ack_i(ack), .req_o(req), .pend_o(pend)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // n rising edges, then settle on the following falling edge
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ack_pin(input int p);
        ack[p] = 1'b1;
        tick(1);
        ack[p] = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 pend during reset", 32'(pend), 0);
        check("R1 req during reset", 32'(req), 0);
        rst_n = 1'b1;
        tick(1);
        check("R1 pend after reset", 32'(pend), 0);
        check("R1 req after reset", 32'(req), 0);
    endtask

    task automatic t_level;
        cfg[1:0] = 2'b00;
        pin[0] = 1'b0;
        tick(1);
        check("R5 level not yet after one edge", 32'(req[0]), 0);
        tick(1);
        check("R2 level request", 32'(req[0]), 1);
        check("R5 level after two edges", 32'(req[0]), 1);
        check("R2 level not latched", 32'(pend[0]), 0);
        pin[0] = 1'b1;
        tick(1);
        check("R5 level held one edge after release", 32'(req[0]), 1);
        tick(1);
        check("R2 level drops", 32'(req[0]), 0);
        check("R2 no pend after level", 32'(pend[0]), 0);
    endtask

    task automatic t_reserved;
        cfg[1:0] = 2'b01;
        pin[0] = 1'b0;
        tick(3);
        check("R3 reserved no req low", 32'(req[0]), 0);
        pin[0] = 1'b1;
        tick(3);
        check("R3 reserved no pend", 32'(pend[0]), 0);
        check("R3 reserved no req", 32'(req[0]), 0);
    endtask

    task automatic t_fall;
        cfg[1:0] = 2'b10;
        tick(2);
        pin[0] = 1'b0;
        tick(2);
        check("R5 pend not yet after two edges", 32'(pend[0]), 0);
        tick(1);
        check("R4 falling edge caught", 32'(pend[0]), 1);
        check("R7 req with pend", 32'(req[0]), 1);
        check("R12 other pin untouched", 32'(pend[1]), 0);
        ack_pin(0);
        check("R9 ack clears", 32'(pend[0]), 0);
        pin[0] = 1'b1;
        tick(3);
        check("R4 rising ignored in fall mode", 32'(pend[0]), 0);
    endtask

    task automatic t_rise;
        cfg[3:2] = 2'b11;
        pin[1] = 1'b0;
        tick(3);
        check("R4 falling ignored in rise mode", 32'(pend[1]), 0);
        pin[1] = 1'b1;
        tick(3);
        check("R4 rising edge caught", 32'(pend[1]), 1);
        check("R12 pin0 untouched by pin1", 32'(pend[0]), 0);
        ack_pin(0);
        check("R12 ack on pin0 keeps pin1", 32'(pend[1]), 1);
        ack_pin(1);
        check("R9 ack clears pin1", 32'(pend[1]), 0);
    endtask

    task automatic t_pulse;
        cfg[1:0] = 2'b11;
        pin[0] = 1'b0;
        tick(3);
        pin[0] = 1'b1;
        @(negedge clk);
        pin[0] = 1'b0;
        tick(3);
        check("R6 one-period pulse caught", 32'(pend[0]), 1);
        ack_pin(0);
        check("R9 clear after pulse", 32'(pend[0]), 0);
    endtask

    task automatic t_mask;
        mask[0] = 1'b0;
        cfg[1:0] = 2'b10;
        pin[0] = 1'b1;
        tick(3);
        pin[0] = 1'b0;
        tick(3);
        check("R8 masked edge pends", 32'(pend[0]), 1);
        check("R8 masked req low", 32'(req[0]), 0);
        mask[0] = 1'b1;
        #1;
        check("R8 req on unmask", 32'(req[0]), 1);
        gie = 1'b0;
        #1;
        check("R7 gie off blocks", 32'(req[0]), 0);
        gie = 1'b1;
        tick(1);
        ack_pin(0);
        cfg[1:0] = 2'b00;
        tick(3);
        check("R7 level req enabled", 32'(req[0]), 1);
        gie = 1'b0;
        #1;
        check("R7 gie off blocks level", 32'(req[0]), 0);
        gie = 1'b1;
        pin[0] = 1'b1;
        tick(3);
    endtask

    task automatic t_collide;
        cfg[3:2] = 2'b11;
        pin[1] = 1'b0;
        tick(3);
        pin[1] = 1'b1;
        tick(3);
        check("R10 setup pend", 32'(pend[1]), 1);
        pin[1] = 1'b0;
        tick(3);
        check("R9 held without ack", 32'(pend[1]), 1);
        pin[1] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        ack[1] = 1'b1;   // lands on the edge that sees the event
        tick(1);
        ack[1] = 1'b0;
        check("R10 edge with ack keeps pend", 32'(pend[1]), 1);
        ack_pin(1);
        check("R9 plain ack clears", 32'(pend[1]), 0);
        ack_pin(1);
        check("R9 ack when idle no effect", 32'(pend[1]), 0);
        check("R9 ack when idle no req", 32'(req[1]), 0);
    endtask

    task automatic t_mode_switch;
        cfg[1:0] = 2'b00;
        pin[0] = 1'b0;
        tick(3);
        cfg[1:0] = 2'b11;
        tick(3);
        cfg[1:0] = 2'b10;
        tick(3);
        check("R11 switch with pin low", 32'(pend[0]), 0);
        cfg[1:0] = 2'b01;
        pin[0] = 1'b1;
        tick(3);
        cfg[1:0] = 2'b10;
        tick(1);
        cfg[1:0] = 2'b11;
        tick(3);
        check("R11 switch with pin high", 32'(pend[0]), 0);
    endtask

    initial begin
        tick(3);
        t_reset();
        t_level();
        t_reserved();
        t_fall();
        t_rise();
        t_pulse();
        t_mask();
        t_collide();
        t_mode_switch();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule